// File: doc/BRIEF.md
# Single-Wire Slave Bit Interface

This block is the slave-side bit timing engine for a single-wire, open-drain serial bus. The bus idles high, and the master starts every slot by pulling the line low. The block watches a sampled copy of the line. It counts ticks of a fixed system clock and uses those counts to tell four cases apart. A long low pulse is a bus reset. The block answers a reset with a presence pulse. A short low pulse is either a write slot or a read slot. The block drives the line through a single pull-down enable. The pull-up resistor sits outside the block.

An upper layer sits above the block. It receives one strobe for each bit the master writes and a separate strobe for each bus reset. Before a slot starts, the upper layer chooses whether the next slot is a read slot and which bit to send in it. A level input selects one of two timing profiles: standard or overdrive. The block samples that input only while the bus is idle. A reset ends whatever the block is doing, at any point.

Top module: `swire_slave`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `dq_pull`, `rx_valid` and `rst_evt` are all 0.
- R2: The line is a reset when it stays low for 480 us in standard mode or 48 us in overdrive. A reset gives exactly one `rst_evt` pulse, from any state, including a read slot in which the block is pulling the line. The block releases the line on the cycle after `rst_evt`. A shorter low period gives no `rst_evt`.
- R3: After a reset, the block waits for the line to go high. It then leaves the line released for 30 us in standard mode or 3 us in overdrive. Next it pulls the line low for 120 us in standard mode or 12 us in overdrive. It never pulls the line for longer than the standard presence time.
- R4: In a write slot (`rd_en` = 0 at the falling edge), the block samples the line 30 us after the fall in standard mode, or 3 us after in overdrive. It then gives a single-cycle `rx_valid` pulse, with `rx_bit` = 1 if the line was high and 0 if it was low.
- R5: In a read slot (`rd_en` = 1 at the falling edge), the block sends the bit it took at the fall. For a 0, it holds the line low until 30 us after the fall in standard mode, or 4 us in overdrive, and then releases it. For a 1, it leaves the line alone. A read slot gives no `rx_valid`.
- R6: `od_sel` = 1 selects overdrive and `od_sel` = 0 selects standard. The block takes `od_sel` only while the bus is idle, so a change during a slot does not affect that slot.
- R7: The block passes `dq_in` through a two-flop synchronizer before it detects edges. For a read-0 slot, the pull-down starts a few system cycles after the fall.
- R8: `rx_valid` and `rst_evt` are never high in the same cycle. `dq_pull` is never high on a cycle where `rx_valid` is high.
- R9: The block takes `tx_bit` at the falling edge that starts a read slot. Changing `tx_bit` later in that slot has no effect on the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; timing is counted in its ticks |
| rst | input | 1 | Synchronous active-high reset |
| dq_in | input | 1 | Sampled bus level (1 = high) |
| od_sel | input | 1 | Timing profile: 1 = overdrive, 0 = standard |
| rd_en | input | 1 | The next slot is a read slot |
| tx_bit | input | 1 | Bit to send in the next read slot |
| dq_pull | output | 1 | Open-drain pull-down enable (1 = drive line low) |
| rx_valid | output | 1 | One-cycle strobe: a written bit was received |
| rx_bit | output | 1 | Received bit, valid with `rx_valid` |
| rst_evt | output | 1 | One-cycle strobe: a bus reset was detected |

## Verification
The assertions check, on every cycle, the properties that hold regardless of stimulus:
- the two strobes never coincide, and each lasts one cycle;
- the line is released right after a reset;
- the block never pulls the line while it samples a write;
- the pull-down never runs longer than the presence time.

Some behaviour only shows when the bench drives a modelled open-drain bus:
- the actual sample and release points in each profile;
- the reset thresholds, including a low pulse just short of the threshold;
- the presence window;
- a reset cutting into a read-0 slot;
- the insensitivity to mode and transmit-bit changes in the middle of a slot.

// File: rtl/swire_pkg.sv
package swire_pkg;

    // Slot timing in system clock ticks for one profile.
    typedef struct packed {
        int rst_low;   // low duration that counts as a bus reset
        int pgap;      // released gap before the presence pulse
        int plow;      // presence pulse length
        int sample;    // write sample point after the fall
        int hold;      // read-0 hold time after the fall
    } timing_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_WAITHI,
        ST_RSTW,
        ST_GAP,
        ST_PRES
    } slot_st_e;

    // Timing values in microseconds, scaled to clock ticks.
    function automatic timing_t mode_timing(logic od, int tpu);
        timing_t t;
        if (od) begin
            t.rst_low = 48 * tpu;
            t.pgap    = 3 * tpu;
            t.plow    = 12 * tpu;
            t.sample  = 3 * tpu;
            t.hold    = 4 * tpu;
        end else begin
            t.rst_low = 480 * tpu;
            t.pgap    = 30 * tpu;
            t.plow    = 120 * tpu;
            t.sample  = 30 * tpu;
            t.hold    = 30 * tpu;
        end
        return t;
    endfunction

endpackage

// File: rtl/swire_sync.sv
module swire_sync (
    input  logic clk,
    input  logic rst,
    input  logic dq_in,
    output logic line_s,
    output logic fall
);
    logic meta_q;
    logic line_q;
    logic prev_q;

    // Two-flop synchronizer, plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            line_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= dq_in;
            line_q <= meta_q;
            prev_q <= line_q;
        end
    end

    assign line_s = line_q;
    assign fall   = prev_q & ~line_q;
endmodule

// File: rtl/swire_lowtimer.sv
module swire_lowtimer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_s,
    input  logic [TW-1:0] thr,
    output logic          rst_evt
);
    logic [TW-1:0] lo_cnt;

    // Counts consecutive low samples; the count saturates at thr, so one
    // long low period gives a single event.
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt  <= '0;
            rst_evt <= 1'b0;
        end else begin
            rst_evt <= 1'b0;
            if (line_s) begin
                lo_cnt <= '0;
            end else begin
                if (lo_cnt != thr) lo_cnt <= lo_cnt + 1'b1;
                if (lo_cnt == thr - 1'b1) rst_evt <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/swire_slot.sv
module swire_slot
    import swire_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    line_s,
    input  logic    fall,
    input  logic    od_sel,
    input  logic    rd_en,
    input  logic    tx_bit,
    input  logic    rst_evt,
    input  timing_t cur,
    output logic    mode_q,
    output logic    dq_pull,
    output logic    rx_valid,
    output logic    rx_bit
);
    slot_st_e      st;
    logic [TW-1:0] tm;
    logic          rd_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            tm       <= '0;
            rd_slot  <= 1'b0;
            mode_q   <= 1'b0;
            dq_pull  <= 1'b0;
            rx_valid <= 1'b0;
            rx_bit   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rst_evt) begin
                st      <= ST_RSTW;
                tm      <= '0;
                dq_pull <= 1'b0;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        mode_q <= od_sel;
                        if (fall) begin
                            st      <= ST_SLOT;
                            tm      <= '0;
                            rd_slot <= rd_en;
                            dq_pull <= rd_en & ~tx_bit;
                        end
                    end
                    ST_SLOT: begin
                        tm <= tm + 1'b1;
                        if (rd_slot && tm == TW'(cur.hold)) begin
                            dq_pull <= 1'b0;
                            st      <= ST_WAITHI;
                        end else if (!rd_slot && tm == TW'(cur.sample)) begin
                            rx_valid <= 1'b1;
                            rx_bit   <= line_s;
                            st       <= ST_WAITHI;
                        end
                    end
                    ST_WAITHI: begin
                        if (line_s) st <= ST_IDLE;
                    end
                    ST_RSTW: begin
                        if (line_s) begin
                            st <= ST_GAP;
                            tm <= '0;
                        end
                    end
                    ST_GAP: begin
                        tm <= tm + 1'b1;
                        if (tm == TW'(cur.pgap)) begin
                            dq_pull <= 1'b1;
                            tm      <= '0;
                            st      <= ST_PRES;
                        end
                    end
                    ST_PRES: begin
                        tm <= tm + 1'b1;
                        if (tm == TW'(cur.plow)) begin
                            dq_pull <= 1'b0;
                            st      <= ST_WAITHI;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/swire_slave.sv
module swire_slave
    import swire_pkg::*;
#(
    parameter int TICKS_PER_US = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic dq_in,
    input  logic od_sel,
    input  logic rd_en,
    input  logic tx_bit,
    output logic dq_pull,
    output logic rx_valid,
    output logic rx_bit,
    output logic rst_evt
);
    localparam int TW = $clog2(480 * TICKS_PER_US + 2);

    logic    line_s;
    logic    fall;
    logic    mode_q;
    timing_t cur;

    assign cur = mode_timing(mode_q, TICKS_PER_US);

    swire_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .dq_in  (dq_in),
        .line_s (line_s),
        .fall   (fall)
    );

    swire_lowtimer #(.TW(TW)) u_low (
        .clk     (clk),
        .rst     (rst),
        .line_s  (line_s),
        .thr     (TW'(cur.rst_low)),
        .rst_evt (rst_evt)
    );

    swire_slot #(.TW(TW)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .line_s   (line_s),
        .fall     (fall),
        .od_sel   (od_sel),
        .rd_en    (rd_en),
        .tx_bit   (tx_bit),
        .rst_evt  (rst_evt),
        .cur      (cur),
        .mode_q   (mode_q),
        .dq_pull  (dq_pull),
        .rx_valid (rx_valid),
        .rx_bit   (rx_bit)
    );
endmodule

// File: rtl/swire_slave_chk.sv
module swire_slave_chk #(
    parameter int TPU = 50
) (
    input logic clk,
    input logic rst,
    input logic dq_pull,
    input logic rx_valid,
    input logic rst_evt
);
    localparam int PULL_MAX = 120 * TPU + 4;

    logic [31:0] pull_run;

    always_ff @(posedge clk) begin
        if (rst || !dq_pull) pull_run <= '0;
        else                 pull_run <= pull_run + 1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!dq_pull && !rx_valid && !rst_evt));

    assert_rst_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rst_evt |=> !rst_evt);

    assert_release_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
        rst_evt |=> !dq_pull);

    assert_pull_bound_R3: assert property (@(posedge clk) disable iff (rst)
        pull_run <= 32'(PULL_MAX));

    assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rst_evt));

    assert_no_pull_on_sample_R8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !dq_pull);
endmodule

bind swire_slave swire_slave_chk #(.TPU(TICKS_PER_US)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dq_pull  (dq_pull),
    .rx_valid (rx_valid),
    .rst_evt  (rst_evt)
);

// File: tb/tb_swire_slave.sv
module tb_swire_slave;
    localparam int U = 5;  // ticks per microsecond in this bench

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mlow = 1'b0;
    logic od_sel = 1'b0;
    logic rd_en = 1'b0;
    logic tx_bit = 1'b1;
    logic dq_in;
    logic dq_pull, rx_valid, rx_bit, rst_evt;

    int n_chk = 0;
    int n_fail = 0;
    int rx_cnt = 0;
    int rst_cnt = 0;
    bit last_rx = 1'b0;
    bit cur_od = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Open-drain bus: low when either side pulls.
    assign dq_in = ~(mlow | dq_pull);

    swire_slave #(.TICKS_PER_US(U)) dut (
        .clk(clk), .rst(rst), .dq_in(dq_in), .od_sel(od_sel),
        .rd_en(rd_en), .tx_bit(tx_bit), .dq_pull(dq_pull),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rst_evt(rst_evt)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            last_rx <= rx_bit;
        end
        if (rst_evt) rst_cnt <= rst_cnt + 1;
    end

    function automatic bit exp_write(bit b);
        return b;  // R4: a released line reads as 1
    endfunction

    function automatic bit exp_read(bit tx);
        return tx;  // R5: the slave pulls only for 0
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_us(int n);
        repeat (n * U) @(negedge clk);
    endtask

    task automatic bus_reset(bit od, int low_us);
        int r0;
        od_sel = od;
        cur_od = od;
        wait_us(3);
        r0 = rst_cnt;
        mlow = 1'b1;
        wait_us(low_us);
        mlow = 1'b0;
        chk(rst_cnt == r0 + 1, "R2", rst_cnt - r0, 1);
        wait_us(od ? 1 : 10);
        chk(dq_pull == 1'b0, "R3", dq_pull, 0);
        wait_us(od ? 6 : 80);
        chk(dq_pull == 1'b1, "R3", dq_pull, 1);
        wait_us(od ? 13 : 80);
        chk(dq_pull == 1'b0, "R3", dq_pull, 0);
        wait_us(od ? 2 : 10);
    endtask

    task automatic write_bit(bit b);
        int c0;
        c0 = rx_cnt;
        rd_en = 1'b0;
        mlow = 1'b1;
        if (b) begin
            wait_us(1);
            mlow = 1'b0;
            wait_us(cur_od ? 11 : 89);
        end else begin
            wait_us(cur_od ? 8 : 70);
            mlow = 1'b0;
            wait_us(cur_od ? 4 : 20);
        end
        chk(rx_cnt == c0 + 1, "R4", rx_cnt - c0, 1);
        chk(last_rx == exp_write(b), "R4", last_rx, exp_write(b));
        wait_us(2);
    endtask

    task automatic read_bit(bit tx);
        int c0;
        bit seen;
        c0 = rx_cnt;
        rd_en = 1'b1;
        tx_bit = tx;
        mlow = 1'b1;
        wait_us(1);
        mlow = 1'b0;
        tx_bit = ~tx;  // R9: late change must not matter
        wait_us(cur_od ? 1 : 9);
        seen = dq_in;
        chk(seen == exp_read(tx), "R5/R9", seen, exp_read(tx));
        wait_us(cur_od ? 4 : 30);
        chk(dq_pull == 1'b0, "R5", dq_pull, 0);
        wait_us(cur_od ? 6 : 50);
        chk(rx_cnt == c0, "R5", rx_cnt - c0, 0);
        rd_en = 1'b0;
        wait_us(2);
    endtask

    initial begin
        int r0;
        int c0;
        bit b;
        bit op;
        void'($urandom(32'd4242));

        // R1: quiet during reset
        repeat (4) @(negedge clk);
        chk(!dq_pull && !rx_valid && !rst_evt, "R1", dq_pull, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!dq_pull && !rx_valid && !rst_evt, "R1", rst_evt, 0);

        // Standard profile
        bus_reset(1'b0, 500);
        write_bit(1'b1);
        write_bit(1'b0);
        read_bit(1'b0);
        read_bit(1'b1);

        // R2: 400 us low in standard mode is not a reset
        r0 = rst_cnt;
        mlow = 1'b1;
        wait_us(400);
        mlow = 1'b0;
        wait_us(5);
        chk(rst_cnt == r0, "R2", rst_cnt - r0, 0);

        // R2: reset cutting into a read-0 slot (R7 pull starts early)
        r0 = rst_cnt;
        rd_en = 1'b1;
        tx_bit = 1'b0;
        mlow = 1'b1;
        wait_us(1);
        chk(dq_pull == 1'b1, "R7", dq_pull, 1);
        wait_us(499);
        chk(rst_cnt == r0 + 1, "R2", rst_cnt - r0, 1);
        rd_en = 1'b0;
        mlow = 1'b0;
        wait_us(200);

        // Overdrive profile (R6)
        bus_reset(1'b1, 50);
        write_bit(1'b0);
        write_bit(1'b1);
        read_bit(1'b0);

        // R2: 40 us low in overdrive is not a reset
        r0 = rst_cnt;
        mlow = 1'b1;
        wait_us(40);
        mlow = 1'b0;
        wait_us(5);
        chk(rst_cnt == r0, "R2", rst_cnt - r0, 0);

        // R6: mode flip inside an overdrive write slot is ignored
        c0 = rx_cnt;
        mlow = 1'b1;
        repeat (6) @(negedge clk);
        od_sel = 1'b0;
        wait_us(5);
        chk(rx_cnt == c0 + 1, "R6", rx_cnt - c0, 1);
        wait_us(3);
        mlow = 1'b0;
        wait_us(3);
        // Back in idle: the flip to standard now applies
        cur_od = 1'b0;
        write_bit(1'b0);

        // Random mix in both profiles
        for (int g = 0; g < 2; g++) begin
            bus_reset(g[0], g[0] ? 50 : 500);
            for (int i = 0; i < 14; i++) begin
                op = 1'($urandom % 2);
                b  = 1'($urandom % 2);
                if (op) read_bit(b);
                else    write_bit(b);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule